// File: doc/BRIEF.md
# Pre-trigger sample capture buffer

This block sits in a receive path and records a running history of samples. Each accepted sample (one per cycle in which `in_valid` is high) is packed into a 64-bit element and written into a circular memory of `DEPTH` entries. The element carries the I and Q words, a gain word built from the front-end lock flag and 7-bit gain, and an uncalibrated signal-strength word in half-dB steps.

A single-cycle `trig` pulse starts a capture record. The record is sent on a valid/ready stream. It opens with a header word: the 64-bit timer value present on `ts_now` in the trigger cycle. After the header come `rec_len` sample elements. The first of these is the sample accepted `pre_len` samples before the trigger. The look-back distance and the record length are independent of each other, so a record may end before the trigger point or reach well past it. Elements after the trigger point are sent only once their samples have arrived. Triggers that arrive while a record is open are not acted on. They are tallied in a saturating counter.

The stream follows these back-pressure rules. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` do not change and `out_valid` stays high. A word is transferred in each cycle where both are high. Back-pressure never stops sample writes. The consumer must therefore drain a record before `DEPTH` further samples overwrite its unread part. `DEPTH` must be a power of two.

Top module: `capture_pretrig_buf`

## Requirements
- R1: During and right after reset, `out_valid` is low and `drop_count` is zero.
- R2: The first word of a record equals the value of `ts_now` in the cycle where the trigger was accepted.
- R3: Each sample element has this layout: I in bits 15:0, Q in bits 31:16, gain word in bits 47:32, signal strength in bits 63:48. The gain word is `{8'h00, lock, gain[6:0]}`.
- R4: Samples are numbered in arrival order. A sample accepted in the trigger cycle counts as the first one at or after the trigger. Element 0 is the sample `pre_len` positions before that point, and later elements follow in arrival order.
- R5: A record holds exactly `rec_len` elements after the header, and `out_last` is high only on the final word. When `rec_len` is 0, the header alone is sent, with `out_last` high.
- R6: An element is never presented before its sample has been written. Post-trigger elements wait for input.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` and `out_last` hold their values.
- R8: A trigger in a cycle where a record is open, including the cycle of its last transfer, is ignored. It adds one to `drop_count`, which stops at all-ones.
- R9: History addressing wraps modulo `DEPTH`. A record may span the wrap point, with `pre_len` up to `DEPTH-2` and `rec_len` up to `DEPTH-1`.
- R10: `pre_len` and `rec_len` are sampled at the trigger. Changing them during a record has no effect on that record.
- R11: `out_valid` is low whenever no record is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_i | input | 16 | I sample |
| in_q | input | 16 | Q sample |
| in_gain | input | 7 | Front-end gain value |
| in_lock | input | 1 | Front-end gain lock flag |
| in_rssi | input | 16 | Raw signal strength, half-dB steps |
| ts_now | input | 64 | Free-running timer value |
| trig | input | 1 | Capture trigger pulse |
| pre_len | input | $clog2(DEPTH) | Samples to look back from the trigger |
| rec_len | input | $clog2(DEPTH) | Sample elements per record |
| out_valid | output | 1 | Record word valid |
| out_ready | input | 1 | Consumer accepts word |
| out_data | output | 64 | Header or sample element |
| out_last | output | 1 | Final word of the record |
| drop_count | output | DROP_W | Saturating count of ignored triggers |

## Verification
The bench builds the block with `DEPTH` = 64 and `DROP_W` = 4. A record with a 62-sample look-back and 63 elements then spans almost the whole memory, so the wrap point is crossed within a few dozen samples. Fifteen ignored triggers are enough to drive the drop counter into saturation, and the bench fires more than that. The bench varies input density and ready density. This exposes the waits for post-trigger samples and the stalls under back-pressure, and a configuration change in the middle of a record tests the latching.

// File: rtl/cap_pkg.sv
package cap_pkg;

  localparam int ELEM_W = 64;
  localparam int TS_W   = 64;

  typedef struct packed {
    logic [15:0] rssi;
    logic [15:0] gain_w;
    logic [15:0] q;
    logic [15:0] i;
  } cap_elem_t;

  function automatic cap_elem_t pack_elem(
    input logic [15:0] i_s,
    input logic [15:0] q_s,
    input logic [6:0]  gain,
    input logic        lock,
    input logic [15:0] rssi
  );
    cap_elem_t e;
    e.i      = i_s;
    e.q      = q_s;
    e.gain_w = {8'h00, lock, gain};
    e.rssi   = rssi;
    return e;
  endfunction

endpackage

// File: rtl/cap_hist_ram.sv
module cap_hist_ram #(
  parameter int DEPTH = 1024,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [AW-1:0] wr_ptr,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q;

  // write pointer names the slot the next accepted sample lands in
  always_ff @(posedge clk) begin
    if (!rst_n) wp_q <= '0;
    else if (wr_en) wp_q <= wp_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
  end

  // registered read with enable: the read register doubles as output holding stage
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  assign wr_ptr = wp_q;

  assert_wp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_ptr));

endmodule

// File: rtl/cap_drop_ctr.sv
module cap_drop_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  assert_drop_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX) |=> (count == CNT_MAX));

  assert_drop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));

endmodule

// File: rtl/cap_record_seq.sv
module cap_record_seq #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          in_valid,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] pre_len,
  input  logic [AW-1:0] rec_len,
  input  logic [63:0]   ts_now,
  input  logic [63:0]   rd_data,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [63:0]   out_data,
  output logic          out_last,
  output logic          drop_inc
);

  logic          busy_q;
  logic          hdr_q;
  logic [63:0]   ts_q;
  logic [AW-1:0] len_q;
  logic [AW-1:0] k_q;
  logic [AW:0]   avail_q;
  logic [AW-1:0] rd_addr_q;
  logic          ov_q;
  logic          last_q;

  logic          accept;
  logic          slot_free;
  logic          issue;
  logic          done;
  logic [AW:0]   k_next;

  always_comb begin
    accept    = trig && !busy_q;
    drop_inc  = trig && busy_q;
    slot_free = !ov_q || out_ready;
    // element k may be fetched once k < len and sample k has been written
    issue     = busy_q && slot_free && (k_q < len_q) && ({1'b0, k_q} < avail_q);
    done      = ov_q && out_ready && last_q;
    k_next    = {1'b0, k_q} + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      hdr_q     <= 1'b0;
      ts_q      <= '0;
      len_q     <= '0;
      k_q       <= '0;
      avail_q   <= '0;
      rd_addr_q <= '0;
      ov_q      <= 1'b0;
      last_q    <= 1'b0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      hdr_q     <= 1'b1;
      ov_q      <= 1'b1;
      last_q    <= (rec_len == '0);
      ts_q      <= ts_now;
      len_q     <= rec_len;
      k_q       <= '0;
      rd_addr_q <= wr_ptr - pre_len;
      avail_q   <= {1'b0, pre_len} + {{AW{1'b0}}, in_valid};
    end else if (busy_q) begin
      if (in_valid && avail_q < {1'b0, len_q}) avail_q <= avail_q + 1'b1;
      if (issue) begin
        rd_addr_q <= rd_addr_q + 1'b1;
        k_q       <= k_q + 1'b1;
        ov_q      <= 1'b1;
        hdr_q     <= 1'b0;
        last_q    <= (k_next == {1'b0, len_q});
      end else if (ov_q && out_ready) begin
        ov_q <= 1'b0;
      end
      if (done) busy_q <= 1'b0;
    end
  end

  assign rd_en     = issue;
  assign rd_addr   = rd_addr_q;
  assign out_valid = ov_q;
  assign out_last  = last_q;
  assign out_data  = hdr_q ? ts_q : rd_data;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_first_hdr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (out_valid && hdr_q));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy_q);

  assert_record_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  assert_elem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !hdr_q) |-> (k_q != '0 && k_q <= len_q));

endmodule

// File: rtl/capture_pretrig_buf.sv
module capture_pretrig_buf #(
  parameter int DEPTH  = 1024,
  parameter int DROP_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       in_i,
  input  logic [15:0]       in_q,
  input  logic [6:0]        in_gain,
  input  logic              in_lock,
  input  logic [15:0]       in_rssi,
  input  logic [63:0]       ts_now,
  input  logic              trig,
  input  logic [AW-1:0]     pre_len,
  input  logic [AW-1:0]     rec_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [63:0]       out_data,
  output logic              out_last,
  output logic [DROP_W-1:0] drop_count
);

  import cap_pkg::*;

  cap_elem_t     wr_elem;
  logic [AW-1:0] wr_ptr;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [63:0]   rd_data;
  logic          drop_inc;

  assign wr_elem = pack_elem(in_i, in_q, in_gain, in_lock, in_rssi);

  cap_hist_ram #(.DEPTH(DEPTH), .W(ELEM_W)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (in_valid),
    .wr_data (wr_elem),
    .wr_ptr  (wr_ptr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  cap_record_seq #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .in_valid  (in_valid),
    .wr_ptr    (wr_ptr),
    .pre_len   (pre_len),
    .rec_len   (rec_len),
    .ts_now    (ts_now),
    .rd_data   (rd_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .drop_inc  (drop_inc)
  );

  cap_drop_ctr #(.W(DROP_W)) u_drop (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (drop_inc),
    .count (drop_count)
  );

  // a fetch never targets the slot being written in the same cycle while reading is live
  assert_fetch_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_valid && out_ready) |-> (rd_addr != wr_ptr));

endmodule

// File: tb/capture_pretrig_buf_tb.sv
module capture_pretrig_buf_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int AW         = $clog2(DEPTH);
  localparam int DW         = 4;
  localparam int DROP_MAX   = (1 << DW) - 1;
  localparam int WD_LIMIT   = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [15:0]   in_i = '0, in_q = '0, in_rssi = '0;
  logic [6:0]    in_gain = '0;
  logic          in_lock = 1'b0;
  logic [63:0]   ts_now = 64'h1000;
  logic          trig = 1'b0;
  logic [AW-1:0] pre_len = '0, rec_len = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [63:0]   out_data;
  logic          out_last;
  logic [DW-1:0] drop_count;

  capture_pretrig_buf #(.DEPTH(DEPTH), .DROP_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .in_gain(in_gain), .in_lock(in_lock), .in_rssi(in_rssi), .ts_now(ts_now),
    .trig(trig), .pre_len(pre_len), .rec_len(rec_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .drop_count(drop_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int unsigned seed = 32'h1234_5678;

  // stimulus knobs
  int vpct = 100;
  int rpct = 100;
  int cfg_pre = 0;
  int cfg_len = 0;
  bit trig_req = 1'b0;
  string tag = "";

  // reference model
  logic [63:0] hist[$];
  bit          m_busy = 1'b0;
  int          m_pos = 0;
  int          m_len = 0;
  int          m_start = 0;
  logic [63:0] m_ts = '0;
  int          m_drop = 0;
  bit          prev_stall = 1'b0;
  logic [63:0] prev_data = '0;
  logic        prev_last = 1'b0;

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic evaluate();
    bit old_busy;
    int idx;
    old_busy = m_busy;
    check(drop_count == DW'(m_drop), "R8", "drop_count", 64'(drop_count), 64'(m_drop));
    if (!old_busy) check(!out_valid, "R11", "valid while idle", 64'(out_valid), 64'd0);
    if (prev_stall)
      check(out_valid && out_data == prev_data && out_last == prev_last, "R7",
            "hold under stall", out_data, prev_data);
    if (trig && old_busy && m_drop < DROP_MAX) m_drop++;
    if (out_valid && out_ready && old_busy) begin
      if (m_pos == 0) begin
        check(out_data == m_ts, "R2", "header timestamp", out_data, m_ts);
      end else begin
        idx = m_start + m_pos - 1;
        if (idx >= hist.size())
          check(1'b0, "R6", "element before its sample", 64'(idx), 64'(hist.size()));
        else
          check(out_data == hist[idx], {"R3 R4 ", tag}, "element", out_data, hist[idx]);
      end
      check(out_last == (m_pos == m_len), "R5", "last flag", 64'(out_last), 64'(m_pos == m_len));
      if (m_pos == m_len) m_busy = 1'b0;
      m_pos++;
    end
    if (trig && !old_busy) begin
      m_busy  = 1'b1;
      m_pos   = 0;
      m_len   = int'(rec_len);
      m_start = hist.size() - int'(pre_len);
      m_ts    = ts_now;
    end
    if (in_valid) hist.push_back({in_rssi, 8'h00, in_lock, in_gain, in_q, in_i});
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    prev_last  = out_last;
  endtask

  task automatic step();
    @(negedge clk);
    in_valid  = (rnd() % 100) < vpct;
    in_i      = 16'(rnd());
    in_q      = 16'(rnd());
    in_gain   = 7'(rnd());
    in_lock   = rnd() % 2 == 0;
    in_rssi   = 16'(rnd());
    out_ready = (rnd() % 100) < rpct;
    ts_now    = ts_now + 64'(1 + rnd() % 3);
    pre_len   = AW'(cfg_pre);
    rec_len   = AW'(cfg_len);
    trig      = trig_req;
    trig_req  = 1'b0;
    #(CLK_PERIOD/4);
    evaluate();
  endtask

  task automatic fire_and_wait(input int pre, input int len, input string t);
    cfg_pre = pre;
    cfg_len = len;
    tag = t;
    trig_req = 1'b1;
    step();
    for (int i = 0; i < 4000 && m_busy; i++) step();
    check(!m_busy, "R5", {"record completes ", t}, 64'(m_busy), 64'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && drop_count == '0, "R1", "in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #(CLK_PERIOD/4);
    check(!out_valid && drop_count == '0, "R1", "after reset", 64'(drop_count), 64'd0);

    vpct = 100; rpct = 100;
    for (int i = 0; i < 80; i++) step();

    // R4: look-back shorter than record, dense input
    vpct = 75;
    fire_and_wait(10, 20, "R4 basic");
    // R6: no look-back, sparse input so elements wait
    vpct = 30;
    fire_and_wait(0, 30, "R6 post");
    // record ends before trigger point
    vpct = 80;
    fire_and_wait(40, 5, "R4 short");
    // R5: empty record, header only
    fire_and_wait(5, 0, "R5 empty");

    // R7 R10 R8: back-pressure, config change and triggers mid-record
    rpct = 50; vpct = 90;
    cfg_pre = 20; cfg_len = 40; tag = "R10 R7"; trig_req = 1'b1;
    step();
    cfg_pre = 3; cfg_len = 7;
    for (int i = 0; i < 6; i++) step();
    trig_req = 1'b1; step();
    trig_req = 1'b1; step();
    for (int i = 0; i < 4000 && m_busy; i++) step();
    check(!m_busy, "R10", "record with changed config completes", 64'(m_busy), 64'd0);

    // R9: record spanning nearly all of memory across the wrap point
    rpct = 100; vpct = 100;
    fire_and_wait(62, 63, "R9 wrap");
    fire_and_wait(DEPTH - 2, DEPTH - 1, "R9 wrap2");

    // R8: saturation of the ignored-trigger tally
    vpct = 20; rpct = 100;
    cfg_pre = 10; cfg_len = 50; tag = "R8 sat"; trig_req = 1'b1;
    step();
    for (int i = 0; i < 20; i++) begin
      trig_req = 1'b1; step();
      step();
    end
    for (int i = 0; i < 4000 && m_busy; i++) step();
    check(drop_count == DW'(DROP_MAX), "R8", "saturated", 64'(drop_count), 64'(DROP_MAX));

    // mixed back-pressure and sparse input
    vpct = 60; rpct = 30;
    fire_and_wait(15, 25, "R7 mixed");
    fire_and_wait(1, 1, "R5 single");

    rpct = 100;
    for (int i = 0; i < 20; i++) step();
    check(!out_valid, "R11", "idle at end", 64'(out_valid), 64'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule